// File: doc/BRIEF.md
# Queue Occupancy Monitor

This block watches one queue out of a bank of ring-manager queues and turns what it sees into events. A small set of configuration fields picks the queue, the quantity to sample from it (element count, size of the packet at the head, or accumulated byte size), a behaviour, and a pair of limits. All fields are loaded through one update port. Each field has its own bit in an update mask, so a single write can change any subset of them and leave the rest alone.

Every cycle the block registers the chosen quantity of the chosen queue. It also registers that queue's push and pop strobes and whether its element count is zero. A second register stage runs the selected behaviour and drives a one-cycle event pulse plus a sticky interrupt level. Pulsing the status-read input acknowledges the interrupt and restarts the peak record. The current sample, the recorded peak and all configuration fields are visible as read-only outputs.

Top module: `queue_occ_monitor`

## Requirements
- R1: After reset every configuration field is zero (mode 0 = off, source 0, queue 0, both limits 0), and `mon_evt`, `mon_irq`, `stat_sample` and `stat_wmark` are zero.
- R2: On a cycle with `cfg_wr` high, mask bit 0 loads the source, bit 1 the mode, bit 2 the queue number (16 bits), bit 3 the low limit (data0) and bit 4 the high limit (data1). A field whose mask bit is clear keeps its value, and no field changes without `cfg_wr`.
- R3: Source code 0 samples the element count, 1 the head packet size, and 2 the accumulated size of the selected queue. Code 3 acts as code 0. `stat_sample` shows the value one clock edge after it is present at the inputs.
- R4: Mode 0 (and the unused codes 5 to 7) keep `mon_evt` and `mon_irq` low and freeze `stat_wmark`, including against status reads.
- R5: Mode 1 (push/pop) gives a one-cycle `mon_evt` pulse for each push or pop strobe of the selected queue, two clock edges after the strobe. Strobes of other queues give nothing.
- R6: Mode 2 (threshold) pulses `mon_evt` once when the sample enters the region below data0 or the region above data1 from anywhere else. It stays quiet while the sample stays in that region and while the sample is within the limits.
- R7: The limit registers have no effect on events or on the peak record in any mode other than 2.
- R8: Mode 3 (watermark) keeps in `stat_wmark` the largest sample seen and pulses `mon_evt` whenever a new, larger value is recorded.
- R9: A `stat_rd` pulse in any mode other than off clears `mon_irq` and reloads `stat_wmark` with the current sample.
- R10: Mode 4 (starvation) pulses `mon_evt` when a pop strobe of the selected queue arrives while that queue's element count is zero. A pop on a non-empty queue, or on another queue, gives nothing.
- R11: Every `mon_evt` pulse also sets `mon_irq`, which stays high until a status read or until the mode is off.
- R12: After a configuration write, the next clock edge produces no event and no peak update, and the threshold region is reset to within the limits.
- R13: A queue number at or above the queue count selects nothing: the sample reads zero and no strobe is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration update strobe |
| cfg_mask | input | 5 | Per-field update mask |
| cfg_src_in | input | 2 | New source code |
| cfg_mode_in | input | 3 | New mode code |
| cfg_queue_in | input | 16 | New queue number |
| cfg_lo_in | input | VAL_W | New low limit (data0) |
| cfg_hi_in | input | VAL_W | New high limit (data1) |
| q_elem_cnt | input | NUM_Q*VAL_W | Element count per queue |
| q_head_size | input | NUM_Q*VAL_W | Head packet size per queue |
| q_accum_size | input | NUM_Q*VAL_W | Accumulated size per queue |
| q_push | input | NUM_Q | Push strobe per queue |
| q_pop | input | NUM_Q | Pop strobe per queue |
| stat_rd | input | 1 | Status read / acknowledge strobe |
| mon_evt | output | 1 | One-cycle event pulse |
| mon_irq | output | 1 | Sticky interrupt level |
| stat_sample | output | VAL_W | Last registered sample |
| stat_wmark | output | VAL_W | Recorded peak sample |
| cur_src | output | 2 | Current source code |
| cur_mode | output | 3 | Current mode code |
| cur_queue | output | 16 | Current queue number |
| cur_lo | output | VAL_W | Current low limit |
| cur_hi | output | VAL_W | Current high limit |

## Verification
The bench steers the sample across both limits and back. A threshold engine that fires on every cycle, instead of once per crossing, shows a second pulse while the sample sits below data0 or above data1. It sets absurd limits while in watermark mode to catch limits that leak into other behaviours. It issues a write together with a push to expose a stale-configuration event on the cycle after the write. It also targets an out-of-range queue number, pops on an empty queue against a non-empty one, and sends status reads while the mode is off. A design that mishandles these either reports a wrong sample, loses the frozen peak, or pulses where it should stay quiet.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
  localparam int QNUM_W = 16;
  localparam int MASK_W = 5;

  localparam int MB_SRC   = 0;
  localparam int MB_MODE  = 1;
  localparam int MB_QUEUE = 2;
  localparam int MB_LO    = 3;
  localparam int MB_HI    = 4;

  typedef enum logic [1:0] {
    SRC_COUNT = 2'd0,
    SRC_HEAD  = 2'd1,
    SRC_ACCUM = 2'd2,
    SRC_ALT   = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_PP    = 3'd1,
    MODE_THR   = 3'd2,
    MODE_WMARK = 3'd3,
    MODE_STARV = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ZONE_IN    = 2'd0,
    ZONE_BELOW = 2'd1,
    ZONE_ABOVE = 2'd2
  } zone_e;
endpackage

// File: rtl/qmon_cfg_regs.sv
module qmon_cfg_regs
  import qmon_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [MASK_W-1:0] mask,
  input  logic [1:0]        src_in,
  input  logic [2:0]        mode_in,
  input  logic [QNUM_W-1:0] queue_in,
  input  logic [VAL_W-1:0]  lo_in,
  input  logic [VAL_W-1:0]  hi_in,
  output logic [1:0]        src_q,
  output logic [2:0]        mode_q,
  output logic [QNUM_W-1:0] queue_q,
  output logic [VAL_W-1:0]  lo_q,
  output logic [VAL_W-1:0]  hi_q,
  output logic              wr_d1
);
  logic [MASK_W-1:0] upd;
  assign upd = wr ? mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      mode_q  <= '0;
      queue_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      wr_d1   <= 1'b0;
    end else begin
      wr_d1 <= wr;
      if (upd[MB_SRC])   src_q   <= src_in;
      if (upd[MB_MODE])  mode_q  <= mode_in;
      if (upd[MB_QUEUE]) queue_q <= queue_in;
      if (upd[MB_LO])    lo_q    <= lo_in;
      if (upd[MB_HI])    hi_q    <= hi_in;
    end
  end
endmodule

// File: rtl/qmon_sampler.sv
module qmon_sampler
  import qmon_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int VAL_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [QNUM_W-1:0]      sel_q,
  input  logic [1:0]             sel_src,
  input  logic [NUM_Q*VAL_W-1:0] elem_flat,
  input  logic [NUM_Q*VAL_W-1:0] head_flat,
  input  logic [NUM_Q*VAL_W-1:0] accum_flat,
  input  logic [NUM_Q-1:0]       push_in,
  input  logic [NUM_Q-1:0]       pop_in,
  output logic [VAL_W-1:0]       s1_val,
  output logic                   s1_push,
  output logic                   s1_pop,
  output logic                   s1_empty
);
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [VAL_W-1:0] elem_a  [NUM_Q];
  logic [VAL_W-1:0] head_a  [NUM_Q];
  logic [VAL_W-1:0] accum_a [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_unpack
    assign elem_a[g]  = elem_flat [g*VAL_W +: VAL_W];
    assign head_a[g]  = head_flat [g*VAL_W +: VAL_W];
    assign accum_a[g] = accum_flat[g*VAL_W +: VAL_W];
  end

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [VAL_W-1:0] cnt_sel, val_n;
  logic             push_n, pop_n, empty_n;

  assign in_range = ({16'd0, sel_q} < 32'(NUM_Q));
  assign idx      = sel_q[IDX_W-1:0];

  always_comb begin
    cnt_sel = '0;
    val_n   = '0;
    push_n  = 1'b0;
    pop_n   = 1'b0;
    empty_n = 1'b0;
    if (in_range) begin
      cnt_sel = elem_a[idx];
      push_n  = push_in[idx];
      pop_n   = pop_in[idx];
      empty_n = (cnt_sel == '0);
      case (src_e'(sel_src))
        SRC_HEAD:  val_n = head_a[idx];
        SRC_ACCUM: val_n = accum_a[idx];
        default:   val_n = cnt_sel;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_val   <= '0;
      s1_push  <= 1'b0;
      s1_pop   <= 1'b0;
      s1_empty <= 1'b0;
    end else begin
      s1_val   <= val_n;
      s1_push  <= push_n;
      s1_pop   <= pop_n;
      s1_empty <= empty_n;
    end
  end
endmodule

// File: rtl/qmon_engine.sv
module qmon_engine
  import qmon_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [VAL_W-1:0] lo,
  input  logic [VAL_W-1:0] hi,
  input  logic             hold,
  input  logic             rd,
  input  logic [VAL_W-1:0] s1_val,
  input  logic             s1_push,
  input  logic             s1_pop,
  input  logic             s1_empty,
  output logic             evt,
  output logic             irq,
  output logic [VAL_W-1:0] wmark
);
  zone_e zone_q, zone_n;
  logic  active, hit, ev_n, new_peak;

  always_comb begin
    case (mode_e'(mode))
      MODE_PP, MODE_THR, MODE_WMARK, MODE_STARV: active = 1'b1;
      default:                                   active = 1'b0;
    endcase
  end

  always_comb begin
    if (s1_val < lo)      zone_n = ZONE_BELOW;
    else if (s1_val > hi) zone_n = ZONE_ABOVE;
    else                  zone_n = ZONE_IN;
  end

  assign new_peak = (s1_val > wmark);

  always_comb begin
    case (mode_e'(mode))
      MODE_PP:    hit = s1_push | s1_pop;
      MODE_THR:   hit = (zone_n != ZONE_IN) && (zone_n != zone_q);
      MODE_WMARK: hit = new_peak;
      MODE_STARV: hit = s1_pop & s1_empty;
      default:    hit = 1'b0;
    endcase
  end

  assign ev_n = hit & active & ~hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt    <= 1'b0;
      irq    <= 1'b0;
      wmark  <= '0;
      zone_q <= ZONE_IN;
    end else begin
      evt    <= ev_n;
      zone_q <= (mode_e'(mode) == MODE_THR && !hold) ? zone_n : ZONE_IN;
      if (!active) irq <= 1'b0;
      else         irq <= ev_n | (irq & ~rd);
      if (active) begin
        if (rd)
          wmark <= s1_val;
        else if (mode_e'(mode) == MODE_WMARK && !hold && new_peak)
          wmark <= s1_val;
      end
    end
  end
endmodule

// File: rtl/queue_occ_monitor.sv
module queue_occ_monitor
  import qmon_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int VAL_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [4:0]             cfg_mask,
  input  logic [1:0]             cfg_src_in,
  input  logic [2:0]             cfg_mode_in,
  input  logic [15:0]            cfg_queue_in,
  input  logic [VAL_W-1:0]       cfg_lo_in,
  input  logic [VAL_W-1:0]       cfg_hi_in,
  input  logic [NUM_Q*VAL_W-1:0] q_elem_cnt,
  input  logic [NUM_Q*VAL_W-1:0] q_head_size,
  input  logic [NUM_Q*VAL_W-1:0] q_accum_size,
  input  logic [NUM_Q-1:0]       q_push,
  input  logic [NUM_Q-1:0]       q_pop,
  input  logic                   stat_rd,
  output logic                   mon_evt,
  output logic                   mon_irq,
  output logic [VAL_W-1:0]       stat_sample,
  output logic [VAL_W-1:0]       stat_wmark,
  output logic [1:0]             cur_src,
  output logic [2:0]             cur_mode,
  output logic [15:0]            cur_queue,
  output logic [VAL_W-1:0]       cur_lo,
  output logic [VAL_W-1:0]       cur_hi
);
  logic wr_d1, s1_push, s1_pop, s1_empty;

  qmon_cfg_regs #(.VAL_W(VAL_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .mask(cfg_mask),
    .src_in(cfg_src_in), .mode_in(cfg_mode_in), .queue_in(cfg_queue_in),
    .lo_in(cfg_lo_in), .hi_in(cfg_hi_in),
    .src_q(cur_src), .mode_q(cur_mode), .queue_q(cur_queue),
    .lo_q(cur_lo), .hi_q(cur_hi), .wr_d1(wr_d1)
  );

  qmon_sampler #(.NUM_Q(NUM_Q), .VAL_W(VAL_W)) u_smp (
    .clk(clk), .rst(rst), .sel_q(cur_queue), .sel_src(cur_src),
    .elem_flat(q_elem_cnt), .head_flat(q_head_size), .accum_flat(q_accum_size),
    .push_in(q_push), .pop_in(q_pop),
    .s1_val(stat_sample), .s1_push(s1_push), .s1_pop(s1_pop), .s1_empty(s1_empty)
  );

  qmon_engine #(.VAL_W(VAL_W)) u_eng (
    .clk(clk), .rst(rst), .mode(cur_mode), .lo(cur_lo), .hi(cur_hi),
    .hold(wr_d1), .rd(stat_rd), .s1_val(stat_sample),
    .s1_push(s1_push), .s1_pop(s1_pop), .s1_empty(s1_empty),
    .evt(mon_evt), .irq(mon_irq), .wmark(stat_wmark)
  );
endmodule

// File: rtl/qmon_checker.sv
module qmon_checker #(
  parameter int VAL_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [4:0]       cfg_mask,
  input logic             stat_rd,
  input logic [2:0]       cur_mode,
  input logic [15:0]      cur_queue,
  input logic [VAL_W-1:0] cur_lo,
  input logic             mon_evt,
  input logic             mon_irq,
  input logic [VAL_W-1:0] stat_wmark
);
  a_r2_masked_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_mask[1]) |=> $stable(cur_mode));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(cur_mode) && $stable(cur_queue) && $stable(cur_lo)));

  a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 3'd0) |=> (!mon_evt && !mon_irq));

  a_r4_off_frozen: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 3'd0) |=> $stable(stat_wmark));

  a_r8_peak_monotone: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 3'd3 && !stat_rd) |=> (stat_wmark >= $past(stat_wmark)));

  a_r11_evt_sets_irq: assert property (@(posedge clk) disable iff (rst)
    mon_evt |-> mon_irq);

  a_r12_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> ##2 !mon_evt);
endmodule

bind queue_occ_monitor qmon_checker #(.VAL_W(VAL_W)) u_qmon_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask), .stat_rd(stat_rd),
  .cur_mode(cur_mode), .cur_queue(cur_queue), .cur_lo(cur_lo),
  .mon_evt(mon_evt), .mon_irq(mon_irq), .stat_wmark(stat_wmark)
);

// File: tb/test_queue_occ_monitor.sv
module test_queue_occ_monitor;
  localparam int NQ = 8;
  localparam int W  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cfg_wr = 1'b0;
  logic [4:0]    cfg_mask = '0;
  logic [1:0]    cfg_src_in = '0;
  logic [2:0]    cfg_mode_in = '0;
  logic [15:0]   cfg_queue_in = '0;
  logic [W-1:0]  cfg_lo_in = '0, cfg_hi_in = '0;
  logic [W-1:0]  cnt [NQ], head [NQ], acc [NQ];
  logic [NQ*W-1:0] cnt_f, head_f, acc_f;
  logic [NQ-1:0] q_push = '0, q_pop = '0;
  logic          stat_rd = 1'b0;
  logic          mon_evt, mon_irq;
  logic [W-1:0]  stat_sample, stat_wmark, cur_lo, cur_hi;
  logic [1:0]    cur_src;
  logic [2:0]    cur_mode;
  logic [15:0]   cur_queue;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      cnt_f [i*W +: W] = cnt[i];
      head_f[i*W +: W] = head[i];
      acc_f [i*W +: W] = acc[i];
    end
  end

  queue_occ_monitor #(.NUM_Q(NQ), .VAL_W(W)) i_queue_occ_monitor (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
    .cfg_src_in(cfg_src_in), .cfg_mode_in(cfg_mode_in), .cfg_queue_in(cfg_queue_in),
    .cfg_lo_in(cfg_lo_in), .cfg_hi_in(cfg_hi_in),
    .q_elem_cnt(cnt_f), .q_head_size(head_f), .q_accum_size(acc_f),
    .q_push(q_push), .q_pop(q_pop), .stat_rd(stat_rd),
    .mon_evt(mon_evt), .mon_irq(mon_irq), .stat_sample(stat_sample),
    .stat_wmark(stat_wmark), .cur_src(cur_src), .cur_mode(cur_mode),
    .cur_queue(cur_queue), .cur_lo(cur_lo), .cur_hi(cur_hi)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  bit    finished = 1'b0;

  function automatic logic [31:0] actual(int kind);
    case (kind)
      0: return 32'(mon_evt);
      1: return 32'(mon_irq);
      2: return stat_sample;
      3: return stat_wmark;
      4: return 32'(cur_src);
      5: return 32'(cur_mode);
      6: return 32'(cur_queue);
      7: return cur_lo;
      default: return cur_hi;
    endcase
  endfunction

  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] a;
        it = sb.pop_front();
        a  = actual(it.kind);
        n_chk++;
        if (a !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, a, it.exp);
        end
      end
    end
  end

  task automatic expect_v(int kind, logic [31:0] v, string req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic look();
    -> chk_ev;
    #1;
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cfg(logic [4:0] m, logic [1:0] s, logic [2:0] md,
                     logic [15:0] q, logic [W-1:0] lo, logic [W-1:0] hi);
    cfg_wr = 1'b1; cfg_mask = m; cfg_src_in = s; cfg_mode_in = md;
    cfg_queue_in = q; cfg_lo_in = lo; cfg_hi_in = hi;
    step();
    cfg_wr = 1'b0;
    step();
  endtask

  task automatic strobe_push(int q);
    q_push[q] = 1'b1; step(); q_push = '0; step();
  endtask

  task automatic strobe_pop(int q);
    q_pop[q] = 1'b1; step(); q_pop = '0; step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin
      cnt[i] = '0; head[i] = 32'(i + 200); acc[i] = 32'(i + 400);
    end
    step(3);
    rst = 1'b0;
    step();
    // R1 reset state
    expect_v(5, 0, "R1"); expect_v(4, 0, "R1"); expect_v(6, 0, "R1");
    expect_v(7, 0, "R1"); expect_v(8, 0, "R1"); expect_v(0, 0, "R1");
    expect_v(1, 0, "R1"); expect_v(3, 0, "R1"); expect_v(2, 0, "R1");
    look();

    // R2 masked updates
    cfg(5'h1F, 2'd0, 3'd1, 16'd2, 10, 100);
    expect_v(4, 0, "R2"); expect_v(5, 1, "R2"); expect_v(6, 2, "R2");
    expect_v(7, 10, "R2"); expect_v(8, 100, "R2");
    look();
    cfg(5'b00010, 2'd3, 3'd3, 16'd5, 77, 88);
    expect_v(5, 3, "R2"); expect_v(4, 0, "R2"); expect_v(6, 2, "R2");
    expect_v(7, 10, "R2"); expect_v(8, 100, "R2");
    look();
    cfg(5'b00010, 2'd0, 3'd1, 16'd0, 0, 0);

    // R5 push/pop
    strobe_push(2);
    expect_v(0, 1, "R5"); expect_v(1, 1, "R11"); look();
    step(); expect_v(0, 0, "R5"); look();
    strobe_push(3);
    expect_v(0, 0, "R5 other queue"); look();
    strobe_pop(2);
    expect_v(0, 1, "R5 pop"); look();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    expect_v(1, 0, "R9 irq clear"); expect_v(3, 0, "R9"); look();

    // R3 source selection
    cnt[2] = 7; head[2] = 50; acc[2] = 300;
    step();
    expect_v(2, 7, "R3 count"); look();
    cfg(5'b00001, 2'd1, 3'd0, 16'd0, 0, 0);
    expect_v(2, 50, "R3 head"); look();
    cfg(5'b00001, 2'd2, 3'd0, 16'd0, 0, 0);
    expect_v(2, 300, "R3 accum"); look();
    cfg(5'b00001, 2'd3, 3'd0, 16'd0, 0, 0);
    expect_v(2, 7, "R3 code3"); look();

    // R13 out-of-range queue
    cfg(5'b00100, 2'd0, 3'd0, 16'd9, 0, 0);
    expect_v(2, 0, "R13 sample"); look();
    q_push = '1; step(); q_push = '0; step();
    expect_v(0, 0, "R13 strobe"); look();
    cfg(5'b00100, 2'd0, 3'd0, 16'd2, 0, 0);

    // R6 threshold crossings (count=7, lo=10, hi=100)
    cfg(5'b00010, 2'd0, 3'd2, 16'd0, 0, 0);
    step(); expect_v(0, 1, "R6 enter below"); look();
    step(); expect_v(0, 0, "R6 once per crossing"); look();
    cnt[2] = 50; step(2); expect_v(0, 0, "R6 in band"); look();
    cnt[2] = 150; step(2); expect_v(0, 1, "R6 above"); look();
    step(); expect_v(0, 0, "R6 above once"); look();
    cnt[2] = 200; step(2); expect_v(0, 0, "R6 stay above"); look();
    cnt[2] = 5; step(2); expect_v(0, 1, "R6 above to below"); look();

    // R8 watermark
    cfg(5'b00010, 2'd0, 3'd3, 16'd0, 0, 0);
    step(); expect_v(3, 5, "R8 first"); expect_v(0, 1, "R8 new peak"); look();
    step(); expect_v(0, 0, "R8"); look();
    cnt[2] = 3; step(2); expect_v(3, 5, "R8 keep max"); expect_v(0, 0, "R8"); look();
    cnt[2] = 20; step(2); expect_v(3, 20, "R8 rise"); expect_v(0, 1, "R8 rise evt"); look();

    // R7 limits ignored outside threshold mode
    cfg(5'b11000, 2'd0, 3'd0, 16'd0, 1000, 0);
    cnt[2] = 10; step(2);
    expect_v(0, 0, "R7"); expect_v(3, 20, "R7"); look();

    // R9 read reload
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    expect_v(3, 10, "R9 reload"); expect_v(1, 0, "R9 irq"); look();

    // R4 off mode
    cfg(5'b00010, 2'd0, 3'd0, 16'd0, 0, 0);
    cnt[2] = 500; step(2);
    expect_v(3, 10, "R4 frozen"); expect_v(0, 0, "R4"); expect_v(1, 0, "R4"); look();
    strobe_push(2); expect_v(0, 0, "R4 push"); look();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    expect_v(3, 10, "R4 read"); look();

    // R10 starvation
    cnt[2] = 0; cnt[5] = 0;
    cfg(5'b00010, 2'd0, 3'd4, 16'd0, 0, 0);
    strobe_pop(2); expect_v(0, 1, "R10 empty pop"); look();
    cnt[2] = 4; step();
    strobe_pop(2); expect_v(0, 0, "R10 nonempty"); look();
    strobe_pop(5); expect_v(0, 0, "R10 other queue"); look();

    // R12 write suppresses the next edge
    cfg_wr = 1'b1; cfg_mask = 5'b00010; cfg_mode_in = 3'd1; q_push[2] = 1'b1;
    step();
    cfg_wr = 1'b0; q_push = '0;
    step();
    expect_v(0, 0, "R12"); expect_v(5, 1, "R12"); look();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule